// File: doc/BRIEF.md
# Register File Read-Port Precharge Control

This block drives the read-bitline precharge enables of a multiported register file in a multi-issue core. Each read port can be switched off in each subbank separately. A port that carries no operand this cycle is switched off everywhere. A port that carries an operand is precharged only in subbanks that still hold at least one live register. A subbank whose registers are all on the free list stays dark for every port.

The front end knows the number of instructions issuing and which of their source operands exist before it knows which registers they name. That early information is presented together with one dead flag per subbank. The block registers the resulting port-by-subbank enable matrix, so the enables are in place for the read in the following cycle. A saturating counter adds up how many ports sat idle in each cycle, for power statistics.

Top module: `rf_rdport_precharge`

## Requirements
- R1: While `rst_n` is low, every bit of `pre_en` is 0 and `idle_count` is 0.
- R2: Issue slot s owns read ports 2s and 2s+1. Port p is requested in a cycle when `src_need[p]` is 1 and slot p/2 is below the effective issue count.
- R3: One clock edge after the inputs are presented, bit p*BANKS+b of `pre_en` equals (port p requested) AND NOT `bank_dead[b]`.
- R4: `src_need` bits of slots at or above the issue count have no effect. With `issue_count` = 0, every bit of `pre_en` is 0.
- R5: A slot whose instruction has one source operand (second `src_need` bit 0) gets no enable on its second port in any subbank.
- R6: A subbank with `bank_dead[b]` = 1 gets no enable on any port.
- R7: An `issue_count` above the slot count (5 to 7 by default) is treated as the slot count.
- R8: One clock edge after the inputs are presented, `idle_count` has grown by the number of ports that are not requested.
- R9: `idle_count` saturates at all ones and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_count | input | $clog2(SLOTS+1) | Number of instructions issuing this cycle |
| src_need | input | SLOTS*SRCS | Source-operand-present flags, bit 2s+k for slot s operand k |
| bank_dead | input | BANKS | 1 when every register in that subbank is dead |
| pre_en | output | SLOTS*SRCS*BANKS | Registered precharge enables, bit p*BANKS+b |
| idle_count | output | CNT_W | Saturating total of idle port-cycles |

## Verification
Both outputs are due exactly one rising edge after the inputs that decide them. The bench changes its inputs on the falling edge and computes the expected matrix and count from those inputs. It then waits through one rising edge and compares on the next falling edge. The expected count is carried forward cycle by cycle, so one missed or doubled increment shows up in every later check.

// File: rtl/rf_rdpre_pkg.sv
package rf_rdpre_pkg;

   // Default geometry of the register file read side.
   localparam int unsigned DEF_SLOTS = 4;
   localparam int unsigned DEF_SRCS  = 2;
   localparam int unsigned DEF_BANKS = 4;
   localparam int unsigned DEF_CNT_W = 16;

   // Subbank gating variant.
   typedef enum logic {
      GATE_PORT_ONLY = 1'b0,
      GATE_PORT_BANK = 1'b1
   } gate_mode_e;

endpackage

// File: rtl/rf_rdpre_port_decode.sv
module rf_rdpre_port_decode #(
   parameter int unsigned SLOTS = 4,
   parameter int unsigned SRCS  = 2,
   localparam int unsigned PORTS = SLOTS * SRCS,
   localparam int unsigned CW    = $clog2(SLOTS + 1),
   localparam int unsigned PCW   = $clog2(PORTS + 1)
) (
   input  logic [CW-1:0]    issue_count,
   input  logic [PORTS-1:0] src_need,
   output logic [PORTS-1:0] port_req,
   output logic [PCW-1:0]   idle_ports
);

   logic [CW-1:0] eff_count;

   // Clamp out-of-range issue counts to the slot count.
   always_comb begin
      if (issue_count > CW'(SLOTS)) eff_count = CW'(SLOTS);
      else                          eff_count = issue_count;
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      localparam int unsigned SLOT = p / SRCS;
      assign port_req[p] = src_need[p] && (CW'(SLOT) < eff_count);
   end

   always_comb begin
      idle_ports = '0;
      for (int p = 0; p < PORTS; p++) begin
         if (!port_req[p]) idle_ports = idle_ports + PCW'(1);
      end
   end

endmodule

// File: rtl/rf_rdpre_enable_matrix.sv
module rf_rdpre_enable_matrix
   import rf_rdpre_pkg::*;
#(
   parameter int unsigned PORTS     = 8,
   parameter int unsigned BANKS     = 4,
   parameter gate_mode_e  GATE_MODE = GATE_PORT_BANK
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PORTS-1:0]       port_req,
   input  logic [BANKS-1:0]       bank_dead,
   output logic [PORTS*BANKS-1:0] pre_en
);

   logic [PORTS*BANKS-1:0] en_d;

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         if (GATE_MODE == GATE_PORT_BANK) begin : g_gated
            assign en_d[p*BANKS+b] = port_req[p] & ~bank_dead[b];
         end else begin : g_ungated
            assign en_d[p*BANKS+b] = port_req[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_en <= '0;
      else        pre_en <= en_d;
   end

endmodule

// File: rtl/rf_rdpre_idle_counter.sv
module rf_rdpre_idle_counter #(
   parameter int unsigned PCW   = 4,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PCW-1:0]   idle_ports,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W:0] sum;

   assign sum = {1'b0, count} + {{(CNT_W + 1 - PCW){1'b0}}, idle_ports};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         count <= '0;
      else if (sum[CNT_W]) count <= '1;
      else                count <= sum[CNT_W-1:0];
   end

endmodule

// File: rtl/rf_rdport_precharge.sv
module rf_rdport_precharge
   import rf_rdpre_pkg::*;
#(
   parameter int unsigned SLOTS     = DEF_SLOTS,
   parameter int unsigned SRCS      = DEF_SRCS,
   parameter int unsigned BANKS     = DEF_BANKS,
   parameter int unsigned CNT_W     = DEF_CNT_W,
   parameter gate_mode_e  GATE_MODE = GATE_PORT_BANK,
   localparam int unsigned PORTS = SLOTS * SRCS,
   localparam int unsigned CW    = $clog2(SLOTS + 1),
   localparam int unsigned PCW   = $clog2(PORTS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CW-1:0]          issue_count,
   input  logic [PORTS-1:0]       src_need,
   input  logic [BANKS-1:0]       bank_dead,
   output logic [PORTS*BANKS-1:0] pre_en,
   output logic [CNT_W-1:0]       idle_count
);

   initial begin
      if (SLOTS < 1 || SRCS < 1 || BANKS < 1)
         $fatal(1, "rf_rdport_precharge: SLOTS, SRCS and BANKS must be at least 1");
      if (CNT_W < PCW)
         $fatal(1, "rf_rdport_precharge: CNT_W is too narrow for one cycle of idle ports");
   end

   logic [PORTS-1:0] port_req;
   logic [PCW-1:0]   idle_ports;

   rf_rdpre_port_decode #(
      .SLOTS (SLOTS),
      .SRCS  (SRCS)
   ) u_decode (
      .issue_count (issue_count),
      .src_need    (src_need),
      .port_req    (port_req),
      .idle_ports  (idle_ports)
   );

   rf_rdpre_enable_matrix #(
      .PORTS     (PORTS),
      .BANKS     (BANKS),
      .GATE_MODE (GATE_MODE)
   ) u_matrix (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_req  (port_req),
      .bank_dead (bank_dead),
      .pre_en    (pre_en)
   );

   rf_rdpre_idle_counter #(
      .PCW   (PCW),
      .CNT_W (CNT_W)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .idle_ports (idle_ports),
      .count      (idle_count)
   );

endmodule

// File: rtl/rf_rdport_precharge_chk.sv
module rf_rdport_precharge_chk #(
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned SRCS   = 2,
   parameter int unsigned BANKS  = 4,
   parameter int unsigned CNT_W  = 16,
   parameter bit          GATED  = 1'b1,
   localparam int unsigned PORTS = SLOTS * SRCS,
   localparam int unsigned CW    = $clog2(SLOTS + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [CW-1:0]          issue_count,
   input logic [PORTS-1:0]       src_need,
   input logic [BANKS-1:0]       bank_dead,
   input logic [PORTS*BANKS-1:0] pre_en,
   input logic [CNT_W-1:0]       idle_count
);

   logic started;
   logic [BANKS-1:0] bank_any;
   logic [PORTS-1:0] port_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   always_comb begin
      bank_any = '0;
      port_any = '0;
      for (int p = 0; p < PORTS; p++) begin
         for (int b = 0; b < BANKS; b++) begin
            bank_any[b] = bank_any[b] | pre_en[p*BANKS+b];
            port_any[p] = port_any[p] | pre_en[p*BANKS+b];
         end
      end
   end

   assert_no_issue_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      started && ($past(issue_count) == '0) |-> (pre_en == '0));

   assert_no_unneeded_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> ((port_any & ~$past(src_need)) == '0));

   if (GATED) begin : g_dead
      assert_dead_bank_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
         started |-> ((bank_any & $past(bank_dead)) == '0));
   end

   assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> ((idle_count - $past(idle_count)) <= CNT_W'(PORTS)));

   assert_count_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (idle_count >= $past(idle_count)));

endmodule

bind rf_rdport_precharge rf_rdport_precharge_chk #(
   .SLOTS (SLOTS),
   .SRCS  (SRCS),
   .BANKS (BANKS),
   .CNT_W (CNT_W),
   .GATED (GATE_MODE == rf_rdpre_pkg::GATE_PORT_BANK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_count (issue_count),
   .src_need    (src_need),
   .bank_dead   (bank_dead),
   .pre_en      (pre_en),
   .idle_count  (idle_count)
);

// File: tb/rf_rdport_precharge_test.sv
module rf_rdport_precharge_test;

   localparam int SLOTS = 4;
   localparam int SRCS  = 2;
   localparam int BANKS = 4;
   localparam int PORTS = SLOTS * SRCS;
   localparam int CNT_W = 16;
   localparam int LIMIT_CYCLES = 150000;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [2:0]             issue_count = '0;
   logic [PORTS-1:0]       src_need = '0;
   logic [BANKS-1:0]       bank_dead = '0;
   logic [PORTS*BANKS-1:0] pre_en;
   logic [CNT_W-1:0]       idle_count;

   int checks = 0;
   int errors = 0;
   logic [CNT_W-1:0] exp_cnt = '0;

   always #2 clk = ~clk;

   rf_rdport_precharge uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_count (issue_count),
      .src_need    (src_need),
      .bank_dead   (bank_dead),
      .pre_en      (pre_en),
      .idle_count  (idle_count)
   );

   function automatic logic [PORTS-1:0] want_req(input logic [2:0] ic, input logic [PORTS-1:0] need);
      int eff = (int'(ic) > SLOTS) ? SLOTS : int'(ic);
      logic [PORTS-1:0] r = '0;
      for (int p = 0; p < PORTS; p++) r[p] = need[p] && ((p / SRCS) < eff);
      return r;
   endfunction

   function automatic logic [PORTS*BANKS-1:0] want_en(input logic [PORTS-1:0] r, input logic [BANKS-1:0] d);
      logic [PORTS*BANKS-1:0] e = '0;
      for (int p = 0; p < PORTS; p++)
         for (int b = 0; b < BANKS; b++) e[p*BANKS+b] = r[p] & ~d[b];
      return e;
   endfunction

   function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c, input logic [PORTS-1:0] r);
      int unsigned s = int'(c);
      for (int p = 0; p < PORTS; p++) if (!r[p]) s++;
      if (s > (1 << CNT_W) - 1) s = (1 << CNT_W) - 1;
      return CNT_W'(s);
   endfunction

   task automatic check_en(input string tag, input logic [PORTS*BANKS-1:0] exp);
      checks++;
      if (pre_en !== exp) begin
         errors++;
         $display("FAIL %s pre_en actual %h expected %h", tag, pre_en, exp);
      end
   endtask

   task automatic check_cnt(input string tag);
      checks++;
      if (idle_count !== exp_cnt) begin
         errors++;
         $display("FAIL %s idle_count actual %0d expected %0d", tag, idle_count, exp_cnt);
      end
   endtask

   // Inputs are already driven (at a falling edge); run one rising edge and check at the next falling edge.
   task automatic step(input string tag, input bit chk_cnt);
      logic [PORTS-1:0] r = want_req(issue_count, src_need);
      logic [PORTS*BANKS-1:0] e = want_en(r, bank_dead);
      exp_cnt = next_cnt(exp_cnt, r);
      @(posedge clk);
      @(negedge clk);
      check_en(tag, e);
      if (chk_cnt) check_cnt("R8");
   endtask

   task automatic drive(input logic [2:0] ic, input logic [PORTS-1:0] need, input logic [BANKS-1:0] dead);
      issue_count = ic;
      src_need    = need;
      bank_dead   = dead;
   endtask

   initial begin
      void'($urandom(32'd1234));
      drive(3'd4, '1, '0);
      repeat (3) @(negedge clk);
      check_en("R1", '0);
      exp_cnt = '0;
      check_cnt("R1");
      rst_n = 1'b1;

      drive(3'd4, '1, '0);          step("R2", 1'b1);  // all ports, all banks
      drive(3'd2, '1, '0);          step("R4", 1'b1);  // slots 2,3 ignored
      drive(3'd0, '1, '0);          step("R4", 1'b1);  // nothing issues
      drive(3'd3, 8'b1101_0111, 4'b0000); step("R2", 1'b1);
      drive(3'd4, 8'b0101_0101, '0); step("R5", 1'b1); // single source each slot
      drive(3'd4, '1, 4'b1010);     step("R6", 1'b1);
      drive(3'd4, '1, 4'b1111);     step("R6", 1'b1);
      drive(3'd7, '1, 4'b0001);     step("R7", 1'b1);
      drive(3'd5, 8'b1010_1010, '0); step("R7", 1'b1);

      for (int i = 0; i < 400; i++) begin
         drive(3'($urandom_range(0, 7)), PORTS'($urandom), BANKS'($urandom));
         step("R3", 1'b1);
      end

      drive(3'd0, '0, '0);
      for (int i = 0; i < 8300; i++) step("R9", 1'b0);
      check_cnt("R9");
      drive(3'd1, 8'b0000_0011, '0);
      step("R9", 1'b0);
      check_cnt("R9");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (LIMIT_CYCLES) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule